// File: doc/BRIEF.md
# Logical Device Resource Register Bank

This block holds the per-logical-device configuration registers of a plug-and-play expansion card. The card controller decodes the host's configuration-register accesses and hands this bank a write strobe, an 8-bit register index and a data byte. The bank returns the addressed register's contents on a combinational read path. The stored state is as follows: an enable bit that puts the device on the bus, a conflict-check control register, eight 16-bit I/O base addresses, two interrupt selections and two DMA channel selections.

The bank also answers host I/O reads during a conflict check. While the check is armed and the device is still disabled, a read that falls inside any programmed I/O window gets a fixed signature byte on the following cycle. The software that runs the check uses this byte to detect overlapping decoders. A logical-device reset from the controller returns every register to zero.

Top module: `ldev_cfg_bank`

## Requirements
- R1: Index 0x30 bit 0 is the device enable. It reads back as {7'b0, enable}, and `active_o` equals the stored bit from the cycle after the write.
- R2: Index 0x31 stores bit 1 (check armed) and bit 0 (pattern select). Bits [7:2] read as zero.
- R3: I/O base range k (k = 0..N_IO-1) sits at index 0x60+2k for bits [15:8] and at 0x61+2k for bits [7:0]. All eight bits of each byte read back as written.
- R4: Interrupt entry k (k = 0..1) keeps its level in bits [3:0] at index 0x70+2k. It keeps polarity in bit 1 and type in bit 0 at index 0x71+2k. All other bits read as zero.
- R5: DMA entry k (k = 0..1) at index 0x74+k keeps the channel in bits [2:0], and bits [7:3] read as zero.
- R6: The check response applies when an I/O read (`io_rd_i`) occurs while the check is armed and the device is disabled. The read address must satisfy base <= addr < base+IO_SPAN for some nonzero base, with the comparison done without 16-bit wrap. In that case, on the next cycle `io_hit_o` is 1 and `io_rdata_o` is 0x55 if the pattern bit is 1, or 0xAA if it is 0.
- R7: In every other cycle, `io_hit_o` is 0 and `io_rdata_o` is 0x00. This covers a disabled check, an enabled device, an address outside every window and a zero base.
- R8: A pulse on `ld_reset_i` clears all registers to zero by the next cycle. It overrides a write in the same cycle.
- R9: After asynchronous reset, all registers and both response outputs are zero.
- R10: Indices outside the mapped set read as 0x00, and writes to them change no mapped register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_reset_i | input | 1 | Logical-device reset pulse from the card controller |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register index |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Read data of the indexed register |
| active_o | output | 1 | Device enabled on the bus |
| io_rd_i | input | 1 | Host I/O read cycle |
| io_addr_i | input | 16 | Host I/O read address |
| io_hit_o | output | 1 | Conflict-check response valid |
| io_rdata_o | output | 8 | Conflict-check signature byte |

## Verification
The assertions assume that `ld_reset_i`, `cfg_wr_i` and `io_rd_i` are single-cycle strobes. They also assume that the controller never arms the check and enables the device in the same write sequence without first clearing the check. The bench drives each strobe for one cycle, changes all inputs only at the falling edge, and returns the strobes to zero between operations. In the scenario where the device is enabled while the check is still armed, the bench expects no response and does not treat the case as a protocol error.

// File: rtl/ldev_pkg.sv
package ldev_pkg;
  localparam logic [7:0] ADDR_ACT   = 8'h30;
  localparam logic [7:0] ADDR_CHK   = 8'h31;
  localparam logic [7:0] ADDR_IO0   = 8'h60;
  localparam logic [7:0] ADDR_IRQ0  = 8'h70;
  localparam logic [7:0] ADDR_DMA0  = 8'h74;
  localparam logic [7:0] PAT_SET    = 8'h55;
  localparam logic [7:0] PAT_CLR    = 8'hAA;

  typedef struct packed {
    logic armed;
    logic pat;
  } chk_ctl_t;
endpackage

// File: rtl/ldev_ctrl_regs.sv
module ldev_ctrl_regs
  import ldev_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_reset_i,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_addr_i,
  input  logic [1:0] cfg_wdata_i,
  output logic [7:0] rdata_o,
  output logic       active_o,
  output chk_ctl_t   chk_o
);
  logic     act_q;
  chk_ctl_t chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      chk_q <= '0;
    end else if (ld_reset_i) begin
      act_q <= 1'b0;
      chk_q <= '0;
    end else if (cfg_wr_i) begin
      if (cfg_addr_i == ADDR_ACT) act_q <= cfg_wdata_i[0];
      if (cfg_addr_i == ADDR_CHK) chk_q <= chk_ctl_t'(cfg_wdata_i);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (cfg_addr_i == ADDR_ACT) rdata_o = {7'b0, act_q};
    if (cfg_addr_i == ADDR_CHK) rdata_o = {6'b0, chk_q.armed, chk_q.pat};
  end

  assign active_o = act_q;
  assign chk_o    = chk_q;

  a_r1_active_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !ld_reset_i && cfg_addr_i == ADDR_ACT) |=> (active_o == $past(cfg_wdata_i[0])));
  a_r8_reset_clears_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_reset_i |=> (!active_o && chk_o == '0));
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == ADDR_CHK) |-> (rdata_o[7:2] == 6'b0));
endmodule

// File: rtl/ldev_io_bases.sv
module ldev_io_bases
  import ldev_pkg::*;
#(
  parameter int N_IO    = 8,
  parameter int IO_SPAN = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ld_reset_i,
  input  logic        cfg_wr_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [15:0] io_addr_i,
  output logic        in_win_o
);
  localparam logic [16:0] SPAN_W = 17'(IO_SPAN);

  logic [15:0] base_q [N_IO];
  logic [N_IO-1:0] win_hit;

  for (genvar i = 0; i < N_IO; i++) begin : g_rng
    localparam logic [7:0] A_HI = 8'(int'(ADDR_IO0) + 2*i);
    localparam logic [7:0] A_LO = 8'(int'(ADDR_IO0) + 2*i + 1);
    logic [16:0] lo_b, hi_b, a_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              base_q[i] <= '0;
      else if (ld_reset_i)      base_q[i] <= '0;
      else if (cfg_wr_i) begin
        if (cfg_addr_i == A_HI) base_q[i][15:8] <= cfg_wdata_i;
        if (cfg_addr_i == A_LO) base_q[i][7:0]  <= cfg_wdata_i;
      end
    end

    // widen so a window near 0xFFFF does not wrap
    assign lo_b = {1'b0, base_q[i]};
    assign hi_b = lo_b + SPAN_W;
    assign a_w  = {1'b0, io_addr_i};
    assign win_hit[i] = (base_q[i] != 16'h0) && (a_w >= lo_b) && (a_w < hi_b);

    a_r3_hi_byte_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i && !ld_reset_i && cfg_addr_i == A_HI) |=> (base_q[i][15:8] == $past(cfg_wdata_i)));
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < N_IO; i++) begin
      if (cfg_addr_i == 8'(int'(ADDR_IO0) + 2*i))     rdata_o = base_q[i][15:8];
      if (cfg_addr_i == 8'(int'(ADDR_IO0) + 2*i + 1)) rdata_o = base_q[i][7:0];
    end
  end

  assign in_win_o = |win_hit;
endmodule

// File: rtl/ldev_irq_dma.sv
module ldev_irq_dma
  import ldev_pkg::*;
#(
  parameter int N_IRQ = 2,
  parameter int N_DMA = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_reset_i,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_addr_i,
  input  logic [3:0] cfg_wdata_i,
  output logic [7:0] rdata_o
);
  logic [3:0] lvl_q [N_IRQ];
  logic [1:0] ctl_q [N_IRQ];
  logic [2:0] dma_q [N_DMA];

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    localparam logic [7:0] A_LVL = 8'(int'(ADDR_IRQ0) + 2*i);
    localparam logic [7:0] A_CTL = 8'(int'(ADDR_IRQ0) + 2*i + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q[i] <= '0;
        ctl_q[i] <= '0;
      end else if (ld_reset_i) begin
        lvl_q[i] <= '0;
        ctl_q[i] <= '0;
      end else if (cfg_wr_i) begin
        if (cfg_addr_i == A_LVL) lvl_q[i] <= cfg_wdata_i;
        if (cfg_addr_i == A_CTL) ctl_q[i] <= cfg_wdata_i[1:0];
      end
    end
  end

  for (genvar j = 0; j < N_DMA; j++) begin : g_dma
    localparam logic [7:0] A_DMA = 8'(int'(ADDR_DMA0) + j);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  dma_q[j] <= '0;
      else if (ld_reset_i)                          dma_q[j] <= '0;
      else if (cfg_wr_i && cfg_addr_i == A_DMA)     dma_q[j] <= cfg_wdata_i[2:0];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cfg_addr_i == 8'(int'(ADDR_IRQ0) + 2*i))     rdata_o = {4'b0, lvl_q[i]};
      if (cfg_addr_i == 8'(int'(ADDR_IRQ0) + 2*i + 1)) rdata_o = {6'b0, ctl_q[i]};
    end
    for (int j = 0; j < N_DMA; j++)
      if (cfg_addr_i == 8'(int'(ADDR_DMA0) + j)) rdata_o = {5'b0, dma_q[j]};
  end

  a_r8_reset_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_reset_i |=> (lvl_q[0] == 4'h0 && ctl_q[0] == 2'b0 && dma_q[0] == 3'b0));
endmodule

// File: rtl/ldev_cfg_bank.sv
module ldev_cfg_bank
  import ldev_pkg::*;
#(
  parameter int N_IO    = 8,
  parameter int IO_SPAN = 8,
  parameter int N_IRQ   = 2,
  parameter int N_DMA   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ld_reset_i,
  input  logic        cfg_wr_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  cfg_rdata_o,
  output logic        active_o,
  input  logic        io_rd_i,
  input  logic [15:0] io_addr_i,
  output logic        io_hit_o,
  output logic [7:0]  io_rdata_o
);
  logic [7:0] rd_ctrl, rd_io, rd_res;
  chk_ctl_t   chk;
  logic       in_win;
  logic       hit_d, hit_q;
  logic [7:0] dat_q;

  ldev_ctrl_regs u_ctrl (
    .clk_i, .rst_ni, .ld_reset_i, .cfg_wr_i, .cfg_addr_i,
    .cfg_wdata_i (cfg_wdata_i[1:0]),
    .rdata_o     (rd_ctrl),
    .active_o,
    .chk_o       (chk)
  );

  ldev_io_bases #(.N_IO(N_IO), .IO_SPAN(IO_SPAN)) u_io (
    .clk_i, .rst_ni, .ld_reset_i, .cfg_wr_i, .cfg_addr_i, .cfg_wdata_i,
    .rdata_o   (rd_io),
    .io_addr_i,
    .in_win_o  (in_win)
  );

  ldev_irq_dma #(.N_IRQ(N_IRQ), .N_DMA(N_DMA)) u_res (
    .clk_i, .rst_ni, .ld_reset_i, .cfg_wr_i, .cfg_addr_i,
    .cfg_wdata_i (cfg_wdata_i[3:0]),
    .rdata_o     (rd_res)
  );

  assign cfg_rdata_o = rd_ctrl | rd_io | rd_res;

  // check only answers while the device is off the bus
  assign hit_d = io_rd_i && chk.armed && !active_o && in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      dat_q <= 8'h00;
    end else begin
      hit_q <= hit_d;
      dat_q <= hit_d ? (chk.pat ? PAT_SET : PAT_CLR) : 8'h00;
    end
  end

  assign io_hit_o   = hit_q;
  assign io_rdata_o = dat_q;

  a_r7_no_hit_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> !io_hit_o);
  a_r7_quiet_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |=> (!io_hit_o && io_rdata_o == 8'h00));
  a_r6_signature_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hit_o |-> (io_rdata_o == PAT_SET || io_rdata_o == PAT_CLR));
  a_r6_pattern_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && chk.armed && chk.pat && !active_o) |=> (!io_hit_o || io_rdata_o == PAT_SET));
endmodule

// File: tb/ldev_cfg_bank_test.sv
module ldev_cfg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int SPAN = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_reset_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [7:0]  cfg_addr_i = 8'h00;
  logic [7:0]  cfg_wdata_i = 8'h00;
  logic [7:0]  cfg_rdata_o;
  logic        active_o;
  logic        io_rd_i = 1'b0;
  logic [15:0] io_addr_i = 16'h0;
  logic        io_hit_o;
  logic [7:0]  io_rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldev_cfg_bank uut (
    .clk_i(clk), .rst_ni, .ld_reset_i, .cfg_wr_i, .cfg_addr_i, .cfg_wdata_i,
    .cfg_rdata_o, .active_o, .io_rd_i, .io_addr_i, .io_hit_o, .io_rdata_o
  );

  int errors = 0;
  int checks = 0;
  string req = "R9";

  // behavioural reference state
  int m_act, m_arm, m_pat, m_hit, m_dat;
  int m_base [8];
  int m_lvl [2];
  int m_ctl [2];
  int m_dma [2];

  function automatic void m_clear();
    m_act = 0; m_arm = 0; m_pat = 0;
    foreach (m_base[i]) m_base[i] = 0;
    foreach (m_lvl[i]) begin m_lvl[i] = 0; m_ctl[i] = 0; m_dma[i] = 0; end
  endfunction

  function automatic int m_read(int a);
    if (a == 'h30) return m_act;
    if (a == 'h31) return m_arm * 2 + m_pat;
    if (a >= 'h60 && a < 'h70) return (a % 2 == 0) ? m_base[(a-'h60)/2] / 256 : m_base[(a-'h60)/2] % 256;
    if (a >= 'h70 && a < 'h74) return (a % 2 == 0) ? m_lvl[(a-'h70)/2] : m_ctl[(a-'h70)/2];
    if (a == 'h74 || a == 'h75) return m_dma[a-'h74];
    return 0;
  endfunction

  function automatic int m_inwin(int addr);
    foreach (m_base[i])
      if (m_base[i] != 0 && addr >= m_base[i] && addr < m_base[i] + SPAN) return 1;
    return 0;
  endfunction

  task automatic check(int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: update model at the edge, compare at the falling edge
  task automatic tick();
    int a, d;
    @(posedge clk);
    if (!rst_ni) begin
      m_clear(); m_hit = 0; m_dat = 0;
    end else begin
      m_hit = (io_rd_i && m_arm == 1 && m_act == 0 && m_inwin(int'(io_addr_i)) == 1) ? 1 : 0;
      m_dat = m_hit ? (m_pat ? 'h55 : 'hAA) : 0;
      if (ld_reset_i) m_clear();
      else if (cfg_wr_i) begin
        a = int'(cfg_addr_i); d = int'(cfg_wdata_i);
        if (a == 'h30) m_act = d % 2;
        if (a == 'h31) begin m_arm = (d / 2) % 2; m_pat = d % 2; end
        if (a >= 'h60 && a < 'h70) begin
          if (a % 2 == 0) m_base[(a-'h60)/2] = (m_base[(a-'h60)/2] % 256) + d * 256;
          else            m_base[(a-'h60)/2] = (m_base[(a-'h60)/2] / 256) * 256 + d;
        end
        if (a >= 'h70 && a < 'h74) begin
          if (a % 2 == 0) m_lvl[(a-'h70)/2] = d % 16;
          else            m_ctl[(a-'h70)/2] = d % 4;
        end
        if (a == 'h74 || a == 'h75) m_dma[a-'h74] = d % 8;
      end
    end
    @(negedge clk);
    check(int'(cfg_rdata_o), m_read(int'(cfg_addr_i)), "cfg_rdata_o");
    check(int'(active_o), m_act, "active_o");
    check(int'(io_hit_o), m_hit, "io_hit_o");
    check(int'(io_rdata_o), m_dat, "io_rdata_o");
  endtask

  task automatic wr(int a, int d);
    cfg_wr_i = 1'b1; cfg_addr_i = 8'(a); cfg_wdata_i = 8'(d);
    tick();
    cfg_wr_i = 1'b0;
  endtask

  task automatic rd(int a);
    cfg_addr_i = 8'(a);
    tick();
  endtask

  task automatic io(int addr);
    io_rd_i = 1'b1; io_addr_i = 16'(addr);
    tick();
    io_rd_i = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    m_clear(); m_hit = 0; m_dat = 0;
    req = "R9";
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick();
    rst_ni = 1'b1;
    rd('h30); rd('h31); rd('h60);

    req = "R1";
    wr('h30, 'hFF); rd('h30);
    wr('h30, 'hFE); rd('h30);
    wr('h30, 'h01); wr('h30, 'h00);

    req = "R2";
    wr('h31, 'hFF); rd('h31);
    wr('h31, 'hFE); rd('h31);
    wr('h31, 'h00);

    req = "R3";
    for (int i = 0; i < 16; i++) wr('h60 + i, 'h11 * (i + 1) ^ 'h80);
    for (int i = 0; i < 16; i++) rd('h60 + i);

    req = "R4";
    wr('h70, 'hFF); wr('h71, 'hFF); wr('h72, 'h0A); wr('h73, 'h02);
    for (int i = 0; i < 4; i++) rd('h70 + i);

    req = "R5";
    wr('h74, 'hFC); wr('h75, 'h04); rd('h74); rd('h75);

    req = "R10";
    wr('h32, 'hFF); wr('h20, 'hFF); wr('h76, 'hFF); wr('h6F + 'h80, 'h5A);
    rd('h32); rd('h76); rd('h00); rd('hFF);
    for (int i = 0; i < 6; i++) rd('h70 + i);
    rd('h30); rd('h31); rd('h60);

    req = "R6";
    for (int i = 0; i < 16; i++) wr('h60 + i, 0);
    wr('h60, 'h03); wr('h61, 'h00);
    wr('h62, 'h02); wr('h63, 'h20);
    wr('h6E, 'hFF); wr('h6F, 'hFC);
    wr('h31, 'h02);
    io('h0300); io('h0307); io('h0224); io('hFFFF); io('hFFFC);
    wr('h31, 'h03);
    io('h0300); io('h0227);

    req = "R7";
    io('h0308); io('h02FF); io('h021F); io('h0000); io('h0100);
    wr('h30, 'h01); io('h0300); io('h0220);
    wr('h30, 'h00); wr('h31, 'h01); io('h0300);
    wr('h31, 'h02); wr('h60, 'h00); wr('h61, 'h00); io('h0000); io('h0003);
    io('h0220);

    req = "R8";
    wr('h30, 'h01); wr('h72, 'h07);
    ld_reset_i = 1'b1; cfg_wr_i = 1'b1; cfg_addr_i = 8'h30; cfg_wdata_i = 8'h01;
    tick();
    ld_reset_i = 1'b0; cfg_wr_i = 1'b0;
    rd('h30); rd('h31); rd('h62); rd('h63); rd('h72); rd('h74); rd('h6E);
    io('h0220);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule